// File: doc/BRIEF.md
# Tone-Pair Audio Bit Recovery

This block turns a stream of signed 8-bit audio samples into a stream of data bits. The samples carry a two-tone frequency-shift-keyed signal at eight samples per bit. Each sample arrives with a one-cycle strobe. The block tells the two tones apart by multiplying each sample with the sample taken half a bit earlier. It smooths that product with a two-tap recursive low-pass filter and keeps the sign of the result in a short history register.

A phase counter recovers the bit clock. It advances by a fixed step on every sample. When it wraps, a bit is decided by majority over the three newest sign bits. A tone change seen in the sign history pulls the counter one step toward the middle of its range, which keeps the sampling point centred as the far end drifts.

The decided bits are line-coded as transitions: the block emits a 1 when the newest two decisions match and a 0 when they differ. Each emitted bit comes with a single-cycle valid pulse. Framing, unstuffing and byte assembly are left to the logic downstream.

Top module: `afsk_bit_recovery`

## Requirements
- R1: After reset, `bit_valid` and `bit_out` are 0, the four-sample delay line holds zeros, and the filter state, the sign history, the phase counter and the previous decision are all 0.
- R2: For each strobed sample s[n], the filter input is x[n] = (s[n] * s[n-4]) arithmetically shifted right by 2, where s[n-4] is the sample strobed four strobes earlier.
- R3: The filter output is y[n] = x[n-1] + x[n] + (y[n-1] arithmetically shifted right by 1), computed in 16-bit signed arithmetic.
- R4: Each strobe shifts one bit into bit 0 of the sign history: 1 when y[n] > 0, else 0. The older bits move up one position.
- R5: A tone change is detected on a strobe when, in the updated history, bit 1 differs from bit 3 and bit 0 differs from bit 2.
- R6: On a strobe with a detected tone change, the phase counter first moves +1 if it is below 32, otherwise -1. On every strobe it then advances by 8.
- R7: When the advanced phase reaches 64 or more, 64 is subtracted and one bit is decided on that strobe. With silent input, the first bit appears on the 8th strobe after reset.
- R8: The decided bit is 1 when at least two of bits 0, 1 and 2 of the updated sign history are 1.
- R9: On a deciding strobe, the next cycle carries `bit_valid` = 1 with `bit_out` = 1 if the decision equals the previous decision and 0 if it differs. The previous decision is then replaced.
- R10: A cycle without a strobe changes no state. `bit_valid` is high only in the cycle after a deciding strobe.
- R11: Full-scale input of +127 and -128 in any order is handled without wrap-around: the filter output stays within ±16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 8 | Signed audio sample |
| bit_valid | output | 1 | Pulse marking a recovered bit |
| bit_out | output | 1 | Recovered bit after transition decoding |

## Verification
A phase correction and a bit decision can land on the same strobe. When a tone change is detected while the counter sits within one step of the wrap point, the ±1 correction decides whether that strobe wraps or the next one does. The decision then uses whichever history is current on that strobe. The bench provokes this by stretching some bits to nine samples and keeping the tones in phase across the changes, so detected changes drift through every phase value, including those next to the wrap. Each emitted bit is compared in order against a reference that applies the correction before the advance and the wrap test. A wrong ordering shifts or alters bits and the queue comparison reports it.

// File: rtl/afsk_bit_recovery.sv
module afsk_bit_recovery #(
  parameter int SAMP_W      = 8,
  parameter int DELAY       = 4,
  parameter int ACC_W       = 16,
  parameter int PROD_SHIFT  = 2,
  parameter int PHASE_WRAP  = 64,
  parameter int PHASE_STEP  = 8,
  parameter int PHASE_NUDGE = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [SAMP_W-1:0] smp_data,
  output logic                     bit_valid,
  output logic                     bit_out
);
  localparam int PW      = $clog2(PHASE_WRAP) + 2;
  localparam int HALF    = PHASE_WRAP / 2;
  localparam int HIST_W  = 4;
  localparam int MAXGAIN = PHASE_STEP + PHASE_NUDGE;
  localparam int MIN_GAP = (PHASE_WRAP - MAXGAIN + MAXGAIN - 1) / MAXGAIN;
  localparam int Y_LIM   = 2 ** (2 * SAMP_W - PROD_SHIFT);

  logic signed [SAMP_W-1:0]   dly_q [DELAY];
  logic signed [2*SAMP_W-1:0] mul;
  logic signed [ACC_W-1:0]    prod, x_q, y_q, y_nx;
  logic [HIST_W-1:0]          hist_q, hist_nx;
  logic [PW-1:0]              phase_q, ph_adj, ph_sum;
  logic                       trans, wrap, maj, last_q;
  logic [7:0]                 gap_q;

  assign mul     = dly_q[DELAY-1] * smp_data;
  assign prod    = ACC_W'(mul >>> PROD_SHIFT);
  assign y_nx    = x_q + prod + (y_q >>> 1);
  assign hist_nx = {hist_q[HIST_W-2:0], ~y_nx[ACC_W-1] & (|y_nx)};
  assign trans   = &(hist_nx[1:0] ^ hist_nx[3:2]);
  assign ph_adj  = !trans ? phase_q :
                   (phase_q < PW'(HALF)) ? phase_q + PW'(PHASE_NUDGE)
                                          : phase_q - PW'(PHASE_NUDGE);
  assign ph_sum  = ph_adj + PW'(PHASE_STEP);
  assign wrap    = ph_sum >= PW'(PHASE_WRAP);
  assign maj     = (hist_nx[0] & hist_nx[1]) | (hist_nx[0] & hist_nx[2]) |
                   (hist_nx[1] & hist_nx[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DELAY; i++) dly_q[i] <= '0;
      x_q       <= '0;
      y_q       <= '0;
      hist_q    <= '0;
      phase_q   <= '0;
      last_q    <= 1'b0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (smp_valid) begin
        dly_q[0] <= smp_data;
        for (int i = 1; i < DELAY; i++) dly_q[i] <= dly_q[i-1];
        x_q     <= prod;
        y_q     <= y_nx;
        hist_q  <= hist_nx;
        phase_q <= wrap ? ph_sum - PW'(PHASE_WRAP) : ph_sum;
        if (wrap) begin
          last_q    <= maj;
          bit_out   <= ~(maj ^ last_q);
          bit_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= '0;
    else if (smp_valid) gap_q <= wrap ? 8'd0 : (gap_q == 8'hFF ? gap_q : gap_q + 8'd1);
  end

  p_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(smp_valid));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(phase_q) && $stable(hist_q) && $stable(y_q) && !bit_valid));
  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (((phase_q + PW'(PHASE_WRAP) - $past(phase_q)) % PW'(PHASE_WRAP)) == PW'(PHASE_STEP)
                || ((phase_q + PW'(PHASE_WRAP) - $past(phase_q)) % PW'(PHASE_WRAP)) == PW'(PHASE_STEP + PHASE_NUDGE)
                || ((phase_q + PW'(PHASE_WRAP) - $past(phase_q)) % PW'(PHASE_WRAP)) == PW'(PHASE_STEP - PHASE_NUDGE)));
  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PW'(PHASE_WRAP));
  p_bit_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && wrap) |-> (int'(gap_q) + 1 >= MIN_GAP));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (int'(y_q) <= Y_LIM && int'(y_q) >= -Y_LIM));
endmodule

// File: tb/afsk_bit_recovery_tb.sv
`timescale 1ns/1ps
module afsk_bit_recovery_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic signed [7:0] smp_data = '0;
  logic bit_valid, bit_out;
  int checks = 0, fails = 0, outs = 0;
  bit done = 1'b0;
  bit exp_q[$];

  int m_dly[4];
  int m_x = 0, m_y = 0, m_hist = 0, m_phase = 0, m_last = 0;

  always #2.5 clk = ~clk;

  afsk_bit_recovery dut_i (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_data(smp_data), .bit_valid(bit_valid), .bit_out(bit_out));

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_dly[i] = 0;
    m_x = 0; m_y = 0; m_hist = 0; m_phase = 0; m_last = 0;
  endtask

  // reference following R2..R9
  task automatic model_step(input int s);
    int p, bitv, mj;
    p = (m_dly[3] * s) >>> 2;
    for (int i = 3; i > 0; i--) m_dly[i] = m_dly[i-1];
    m_dly[0] = s;
    m_y = m_x + p + (m_y >>> 1);
    m_x = p;
    bitv = (m_y > 0) ? 1 : 0;
    m_hist = ((m_hist << 1) | bitv) & 15;
    if ((((m_hist ^ (m_hist >> 2)) & 3)) == 3)
      m_phase = (m_phase < 32) ? m_phase + 1 : m_phase - 1;
    m_phase = m_phase + 8;
    if (m_phase >= 64) begin
      m_phase = m_phase - 64;
      mj = ((m_hist & 1) + ((m_hist >> 1) & 1) + ((m_hist >> 2) & 1)) >= 2 ? 1 : 0;
      exp_q.push_back(mj == m_last);
      m_last = mj;
    end
  endtask

  task automatic drive(input int s, input int gap);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = 8'(s);
    model_step(s);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      if (g == 1) begin
        checks++;
        if (bit_valid !== 1'b0) begin
          fails++;
          $display("FAIL R10: bit_valid in idle cycle actual=%b expected=0", bit_valid);
        end
      end
    end
    if (gap == 0) begin end
  endtask

  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      outs++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected bit actual=%b expected=none", bit_out);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (bit_out !== e) begin
          fails++;
          $display("FAIL R9: bit %0d actual=%b expected=%b", outs, bit_out, e);
        end
      end
    end
  end

  task automatic tone_bits(input int nbits, input int amp, input int seed_bits, input int stretch_every, input int gap);
    real ph;
    int tone, nsamp, s;
    ph = 0.0;
    tone = 0;
    for (int b = 0; b < nbits; b++) begin
      if (((seed_bits >> (b % 13)) & 1) == 0) tone = 1 - tone;
      nsamp = (stretch_every != 0 && (b % stretch_every) == stretch_every - 1) ? 9 : 8;
      for (int k = 0; k < nsamp; k++) begin
        ph = ph + 2.0 * 3.14159265358979 * (tone ? 2200.0 : 1200.0) / 9600.0;
        s = $rtoi(amp * $sin(ph));
        if (s > 127) s = 127;
        if (s < -128) s = -128;
        drive(s, gap);
      end
    end
  endtask

  task automatic finish_run();
    repeat (6) @(negedge clk);
    smp_valid = 1'b0;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9: missing bits actual=0 expected=%0d", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    checks++;
    if (bit_valid !== 1'b0 || bit_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs actual=%b%b expected=00", bit_valid, bit_out);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R7: silent input, first bit on 8th strobe, value 1 (R1 zero history, R9)
    for (int i = 0; i < 7; i++) drive(0, 2);
    checks++;
    if (outs != 0) begin
      fails++;
      $display("FAIL R7: bits before 8th strobe actual=%0d expected=0", outs);
    end
    drive(0, 2);
    checks++;
    if (outs != 1) begin
      fails++;
      $display("FAIL R7: bits after 8th strobe actual=%0d expected=1", outs);
    end
    // R2 R3 R4 R5 R8: clean tones, bit-aligned
    tone_bits(40, 100, 13'b1011001110100, 0, 2);
    // R6: drifting bit length forces phase nudges near the wrap point
    tone_bits(60, 90, 13'b0110101100111, 5, 2);
    tone_bits(60, 110, 13'b1100011010110, 3, 2);
    // R11: full-scale square input, back-to-back strobes
    for (int i = 0; i < 64; i++) drive(((i / 2) % 2) ? -128 : 127, 0);
    for (int i = 0; i < 64; i++) drive(((i / 3) % 2) ? -128 : -128 + 255 * (i % 2), 0);
    // R10: long idle, no output and no state change seen in the bit stream
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (20) @(negedge clk);
    checks++;
    if (bit_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: output during idle actual=%b expected=0", bit_valid);
    end
    tone_bits(20, 100, 13'b1001110010101, 0, 1);
    // R1: reset mid-stream restores start state
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (bit_valid !== 1'b0 || bit_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: outputs after second reset actual=%b%b expected=00", bit_valid, bit_out);
    end
    rst_n = 1'b1;
    tone_bits(30, 120, 13'b0011101011010, 4, 2);
    finish_run();
  end
endmodule